// File: doc/BRIEF.md
# Fixed-priority vectored interrupt controller

This block collects five interrupt request lines and picks one to hand to a CPU core. The sources are two external pins, a general-purpose timer, a serial-link timer and a serial-link unit. All five share a single priority level. When several are pending and enabled, the block settles the tie with a fixed polling order. It then offers the winner's fixed program-memory vector to the core.

An 8-bit enable register gates the sources. It has one global enable bit and one enable bit per source. Software writes it through a simple write port and can read it back at any time. The request to the core is a valid/ready pair:
- The block raises `irq_valid` with `irq_vector`.
- The core accepts the request by raising `irq_ready`.
- While `irq_valid` is high and `irq_ready` is low, the offer is held unchanged, however the sources or the enables move in the meantime.

After the handshake, the block issues nothing further until the core pulses `irq_ret` at the end of its service routine. The request flags belong to the peripherals, which clear them. The block never clears a flag, so a disabled request stays pending and is taken as soon as it is enabled.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0, `irq_vector` is 0x000 and `cfg_rdata` is 0x00.
- R2: When several enabled sources are pending, the lowest-numbered one wins. The source numbers are: ext pin A = bit 0, general timer = bit 1, ext pin B = bit 2, link timer = bit 3, link unit = bit 4 of `irq_src`.
- R3: The vector for source i is 8*i + 3. These are 0x003, 0x00B, 0x013, 0x01B and 0x023 for bits 0 to 4.
- R4: The enable register has the global enable at bit 7 and the source enables at bits 4..0, each at the same position as its source in `irq_src`. Bits 6 and 5 ignore writes and read 0. A write with `cfg_we` high takes effect, and appears on `cfg_rdata`, from the next cycle.
- R5: While the global enable bit is 0, no request is offered, whatever the source enable bits hold.
- R6: A pending source whose enable bit is 0 is not offered. If it is still pending once enabled, it is offered.
- R7: From idle, an enabled pending source sampled at a clock edge raises `irq_valid` just after that edge. The vector then stays fixed until the handshake (`irq_valid` and `irq_ready` both high), even if a higher-priority source arrives.
- R8: After the handshake, `irq_valid` falls and `irq_vector` returns to 0x000. No request is offered until `irq_ret` is pulsed. A pulse on `irq_ret` while no request is in service is ignored.
- R9: On the edge where `irq_ret` ends service, arbitration runs at once, using the enable register value held before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 5 | Pending request flags, bit 0 has the highest priority |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable register write data |
| cfg_rdata | output | 8 | Enable register readback |
| irq_valid | output | 1 | Interrupt request offered to the core |
| irq_ready | input | 1 | Core accepts the offered request |
| irq_vector | output | 12 | Vector of the offered request, 0x000 otherwise |
| irq_ret | input | 1 | Return-from-interrupt pulse |

## Verification
Two events can fall in the same cycle here.
- **Return plus enable write.** An `irq_ret` pulse can end service in the same cycle that a write changes the enable register. The bench clears every enable bit while returning, with a source pending. It then expects a request to appear anyway, carrying the vector chosen under the old enables.
- **Source rising plus pending offer.** A higher-priority source can rise while a lower one's offer is waiting for `irq_ready`. The bench holds back ready, raises all sources and expects the original vector to stay put.

An exhaustive sweep covers all 256 enable values against all 32 source patterns. For each pair, the bench computes the winner and its vector arithmetically.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SVC_IDLE  = 2'd0,
    SVC_OFFER = 2'd1,
    SVC_BUSY  = 2'd2
  } svc_state_e;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int N_SRC   = 5,
  parameter int REG_W   = 8,
  parameter int GIE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q,
  output logic             gie,
  output logic [N_SRC-1:0] src_en
);
  localparam logic [REG_W-1:0] KEEP_MASK =
    REG_W'((1 << GIE_BIT) | ((1 << N_SRC) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & KEEP_MASK;
  end

  assign gie    = q[GIE_BIT];
  assign src_en = q[N_SRC-1:0];

  // R4: written value lands next cycle with reserved bits dropped
  assert_wr_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == ($past(wdata) & KEEP_MASK)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 5,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N_SRC-1:0] grant;

  assign grant[0] = pend[0];
  for (genvar i = 1; i < N_SRC; i++) begin : g_chain
    assign grant[i] = pend[i] & ~(|pend[i-1:0]);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = |pend;

  // R2: at most one winner, and it is the lowest pending bit
  assert_one_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_vec_pkg::*;
#(
  parameter int N_SRC    = 5,
  parameter int IDX_W    = $clog2(N_SRC),
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_any,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             ack,
  input  logic             ret,
  output logic             valid,
  output logic [VEC_W-1:0] vector
);
  svc_state_e       st;
  logic [VEC_W-1:0] vec_next;
  logic             arb;

  assign vec_next = VEC_W'(VEC_BASE) + VEC_W'(pick_idx) * VEC_W'(VEC_STEP);
  assign arb      = (st == SVC_IDLE) || ((st == SVC_BUSY) && ret);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SVC_IDLE;
      vector <= '0;
    end else begin
      unique case (st)
        SVC_IDLE: if (pick_any) begin
          st     <= SVC_OFFER;
          vector <= vec_next;
        end
        SVC_OFFER: if (ack) begin
          st     <= SVC_BUSY;
          vector <= '0;
        end
        SVC_BUSY: if (ret) begin
          st     <= pick_any ? SVC_OFFER : SVC_IDLE;
          vector <= pick_any ? vec_next : '0;
        end
        default: st <= SVC_IDLE;
      endcase
    end
  end

  assign valid = (st == SVC_OFFER);

  // R7: an unaccepted offer holds its vector
  assert_offer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> (valid && $stable(vector)));
  // R8: handshake drops the offer
  assert_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ack) |=> !valid);
  // R9: a new offer only starts from an arbitration with a winner
  assert_offer_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(arb) && $past(pick_any)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int N_SRC    = 5,
  parameter int REG_W    = 8,
  parameter int GIE_BIT  = 7,
  parameter int VEC_W    = 12,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ret
);
  localparam int IDX_W = $clog2(N_SRC);

  logic             gie;
  logic [N_SRC-1:0] src_en;
  logic [N_SRC-1:0] masked;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  irq_en_reg #(.N_SRC(N_SRC), .REG_W(REG_W), .GIE_BIT(GIE_BIT)) u_en (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .q(cfg_rdata), .gie(gie), .src_en(src_en)
  );

  assign masked = irq_src & src_en & {N_SRC{gie}};

  irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(masked), .any(pick_any), .idx(pick_idx)
  );

  irq_seq #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pick_any(pick_any), .pick_idx(pick_idx),
    .ack(irq_ready), .ret(irq_ret), .valid(irq_valid), .vector(irq_vector)
  );

  // R5: no offer starts unless global enable was set
  assert_gie_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(gie));
  // R3: an offered vector is one of the source vectors
  assert_vec_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((int'(irq_vector) >= VEC_BASE) &&
                   ((int'(irq_vector) - VEC_BASE) % VEC_STEP == 0) &&
                   ((int'(irq_vector) - VEC_BASE) / VEC_STEP < N_SRC)));
  // R6: a newly offered source was enabled and pending
  assert_src_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> ($past(masked) != '0));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  irq_src = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [11:0] irq_vector;
  logic        irq_ret = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_vec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .irq_ret(irq_ret)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_offer(input bit ev, input int evec, input string req);
    chk(irq_valid == ev, {req, " valid"}, int'(irq_valid), int'(ev));
    chk(int'(irq_vector) == evec, {req, " vector"}, int'(irq_vector), evec);
  endtask

  function automatic int exp_vec(input logic [7:0] en, input logic [4:0] s);
    logic [4:0] m;
    m = s & en[4:0] & {5{en[7]}};
    for (int i = 0; i < 5; i++) if (m[i]) return 8 * i + 3;
    return -1;
  endfunction

  task automatic wr_en(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic finish_service();
    irq_ready = 1'b1; tick(); irq_ready = 1'b0;
    irq_src = '0; irq_ret = 1'b1; tick(); irq_ret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_offer(1'b0, 0, "R1");
    chk(cfg_rdata == 8'h00, "R1 rdata", int'(cfg_rdata), 0);

    // R2 R3 R4 R5 R6: exhaustive enables x sources
    for (int en = 0; en < 256; en++) begin
      for (int s = 0; s < 32; s++) begin
        int ev;
        irq_src = '0;
        wr_en(8'(en));
        chk(cfg_rdata == (8'(en) & 8'h9F), "R4 readback", int'(cfg_rdata), en & 'h9F);
        irq_src = 5'(s);
        tick();
        ev = exp_vec(8'(en), 5'(s));
        if (ev < 0) begin
          chk_offer(1'b0, 0, (en[7] ? "R6" : "R5"));
        end else begin
          chk_offer(1'b1, ev, "R2/R3");
          irq_ready = 1'b1; tick(); irq_ready = 1'b0;
          chk_offer(1'b0, 0, "R8 after ack");
          irq_src = '0; irq_ret = 1'b1; tick(); irq_ret = 1'b0;
          chk_offer(1'b0, 0, "R8 idle");
        end
      end
    end

    // R7 hold while a higher source arrives; R8 stray return ignored
    irq_src = '0;
    wr_en(8'h9F);
    irq_src = 5'b10000;
    tick();
    chk_offer(1'b1, 'h23, "R7 offer");
    irq_src = 5'b11111;
    for (int k = 0; k < 3; k++) begin
      irq_ret = (k == 1);
      tick();
      chk_offer(1'b1, 'h23, "R7 hold");
    end
    irq_ret = 1'b0;
    irq_ready = 1'b1; tick(); irq_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk_offer(1'b0, 0, "R8 no nest");
      tick();
    end
    // R9 return and enable clear in the same cycle: old enables used
    irq_ret = 1'b1; cfg_we = 1'b1; cfg_wdata = 8'h00;
    tick();
    irq_ret = 1'b0; cfg_we = 1'b0;
    chk_offer(1'b1, 'h03, "R9 same-cycle return");
    chk(cfg_rdata == 8'h00, "R9 rdata", int'(cfg_rdata), 0);
    finish_service();
    chk_offer(1'b0, 0, "R5 after clear");

    // R6 pending but disabled, then enabled
    wr_en(8'h80);
    irq_src = 5'b00100;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_offer(1'b0, 0, "R6 disabled");
    end
    wr_en(8'h84);
    chk_offer(1'b0, 0, "R6 write edge");
    tick();
    chk_offer(1'b1, 'h13, "R6 enabled");
    finish_service();
    chk_offer(1'b0, 0, "R8 end");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule